// File: doc/BRIEF.md
# Reload-Gated Programmable Clock Divider

This block divides a parent clock by a small integer and drives a gated divided clock. Software programs it through two 32-bit words on a simple register bus: a control word at offset 0x0 and a ratio word at offset 0x8. One divider channel is built. Its index is 1, and that index picks which control bits belong to it.

A new ratio written into the ratio word is only held in shadow storage at first. It reaches the running divider only after a two-step reload handshake. Software first sets the channel's reload-force bit, then sets the global trigger bit. The handshake validates the held value. The divider then takes it up at the end of the period in progress, so no period is ever cut short. A held value outside the supported set is refused, and a sticky error flag is raised. The control word also carries the channel's gate bit, which forces the output low while it is clear.

Top module: `reload_clkdiv`

## Requirements
- R1: After reset the control word reads 0, the ratio word reads 0x0004_0000 (active ratio 4, nothing stored), and the divided output is low.
- R2: A write at offset 0x0 is read back unchanged in control bits [30:0]. A write to control bit 31 is ignored, and that bit reads the error flag. A write at offset 0x8 is read back unchanged in every bit except [21:16].
- R3: Writing the shadow ratio field (ratio word bits [13:8]) does not change the active ratio or the output period until a reload takes place.
- R4: A reload happens when control bit 1 (channel reload-force) and control bit 8 (global trigger) become set together. Either bit set without the other changes nothing, and so does the trigger with only control bit 0 set.
- R5: Writing zero into control bits [8:0] after a reload leaves the active ratio unchanged.
- R6: For an active ratio N in {4, 5, 6, 8}, the output period is N parent cycles. The output is high for floor(N/2) cycles and low for the remaining cycles.
- R7: While control bit 25 (channel gate) is clear, the divided output stays low.
- R8: A reload of a value outside {4, 5, 6, 8} keeps the previous active ratio and sets control bit 31. That bit stays set until reset.
- R9: A reloaded ratio takes effect only at a period boundary, so every output period equals either the old ratio or the new one.
- R10: Ratio word bits [21:16] read the active ratio.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when set, read when clear |
| bus_addr | input | 4 | Byte offset: 0x0 control, 0x8 ratio |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| div_clk_o | output | 1 | Gated divided clock |

## Verification
The assertions rely on one input assumption: register writes arrive as single-cycle strobes, and the reload handshake is a set of force and trigger followed later by a clear. The properties on the active ratio, the swap timing and the error flag therefore look only at internal state transitions. The bench follows that discipline. Every reload uses the same write order, and each write strobe lasts exactly one cycle. Between the trigger and the clear, the bench waits longer than the longest period, so any pending ratio has been taken up before the next sequence starts.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
   // Supported division ratios of the divider.
   function automatic bit ratio_ok(int unsigned r);
      return (r == 4) || (r == 5) || (r == 6) || (r == 8);
   endfunction
endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int CTRL_OFS  = 0,
   parameter int RATIO_OFS = 8,
   parameter int CH_IDX    = 1,
   parameter int TRIG_BIT  = 8,
   parameter int EN_BASE   = 24,
   parameter int ERR_BIT   = 31,
   parameter int RATIO_W   = 6,
   parameter int RATIO_LSB = 8,
   parameter int ACT_LSB   = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic               err_i,
   input  logic [RATIO_W-1:0] act_i,
   output logic               force_o,
   output logic               trig_o,
   output logic               gate_o,
   output logic [RATIO_W-1:0] shadow_o
);
   localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] RATIO_A = ADDR_W'(RATIO_OFS);
   localparam int GATE_BIT = EN_BASE + CH_IDX;

   logic [DATA_W-1:0] ctrl_q, ratio_q, ctrl_wd, ratio_wd;
   logic wr_ctrl, wr_ratio;

   assign wr_ctrl  = bus_sel && bus_we && (bus_addr == CTRL_A);
   assign wr_ratio = bus_sel && bus_we && (bus_addr == RATIO_A);

   always_comb begin
      ctrl_wd           = bus_wdata;
      ctrl_wd[ERR_BIT]  = 1'b0;
      ratio_wd          = bus_wdata;
      ratio_wd[ACT_LSB +: RATIO_W] = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         ratio_q <= '0;
      end else begin
         if (wr_ctrl)  ctrl_q  <= ctrl_wd;
         if (wr_ratio) ratio_q <= ratio_wd;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_we) begin
         if (bus_addr == CTRL_A) begin
            bus_rdata          = ctrl_q;
            bus_rdata[ERR_BIT] = err_i;
         end else if (bus_addr == RATIO_A) begin
            bus_rdata = ratio_q;
            bus_rdata[ACT_LSB +: RATIO_W] = act_i;
         end
      end
   end

   assign force_o  = ctrl_q[CH_IDX];
   assign trig_o   = ctrl_q[TRIG_BIT];
   assign gate_o   = ctrl_q[GATE_BIT];
   assign shadow_o = ratio_q[RATIO_LSB +: RATIO_W];
endmodule

// File: rtl/cdiv_reload.sv
module cdiv_reload #(
   parameter int RATIO_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               force_i,
   input  logic               trig_i,
   input  logic [RATIO_W-1:0] shadow_i,
   input  logic               wrap_i,
   output logic               pend_valid_o,
   output logic [RATIO_W-1:0] pend_val_o,
   output logic               err_o
);
   import cdiv_pkg::*;

   logic armed, arm_q, fire, legal;

   assign armed = force_i && trig_i;
   assign fire  = armed && !arm_q;
   assign legal = ratio_ok(32'(shadow_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q        <= 1'b0;
         pend_valid_o <= 1'b0;
         pend_val_o   <= '0;
         err_o        <= 1'b0;
      end else begin
         arm_q <= armed;
         if (wrap_i) pend_valid_o <= 1'b0;
         if (fire && legal) begin
            pend_valid_o <= 1'b1;
            pend_val_o   <= shadow_i;
         end
         if (fire && !legal) err_o <= 1'b1;
      end
   end
endmodule

// File: rtl/cdiv_counter.sv
module cdiv_counter #(
   parameter int RATIO_W     = 6,
   parameter int RESET_RATIO = 4,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               gate_i,
   input  logic               pend_valid_i,
   input  logic [RATIO_W-1:0] pend_val_i,
   output logic [RATIO_W-1:0] cnt_o,
   output logic [RATIO_W-1:0] act_o,
   output logic               wrap_o,
   output logic               div_clk_o
);
   localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);
   localparam logic [RATIO_W-1:0] RST = RATIO_W'(RESET_RATIO);

   logic [RATIO_W-1:0] cnt_q, act_q, cnt_d, act_d;

   assign wrap_o = (cnt_q == act_q - ONE);
   assign cnt_d  = wrap_o ? '0 : cnt_q + ONE;
   assign act_d  = (wrap_o && pend_valid_i) ? pend_val_i : act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= RST;
      end else begin
         cnt_q <= cnt_d;
         act_q <= act_d;
      end
   end

   generate
      if (OUT_REG) begin : g_out_reg
         logic out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) out_q <= 1'b0;
            else        out_q <= gate_i && (cnt_d < (act_d >> 1));
         end
         assign div_clk_o = out_q;
      end else begin : g_out_comb
         assign div_clk_o = gate_i && (cnt_q < (act_q >> 1));
      end
   endgenerate

   assign cnt_o = cnt_q;
   assign act_o = act_q;
endmodule

// File: rtl/reload_clkdiv.sv
module reload_clkdiv #(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int CTRL_OFS    = 0,
   parameter int RATIO_OFS   = 8,
   parameter int CH_IDX      = 1,
   parameter int TRIG_BIT    = 8,
   parameter int EN_BASE     = 24,
   parameter int ERR_BIT     = 31,
   parameter int RATIO_W     = 6,
   parameter int RATIO_LSB   = 8,
   parameter int ACT_LSB     = 16,
   parameter int RESET_RATIO = 4,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              div_clk_o
);
   import cdiv_pkg::*;

   if (RATIO_W < 4) begin : g_chk_w
      $error("RATIO_W too small for ratio 8");
   end
   if (CH_IDX >= TRIG_BIT) begin : g_chk_ch
      $error("channel force bit overlaps trigger");
   end
   if (EN_BASE + CH_IDX >= ERR_BIT) begin : g_chk_en
      $error("gate bit overlaps error bit");
   end
   if (RATIO_LSB + RATIO_W > ACT_LSB || ACT_LSB + RATIO_W > DATA_W) begin : g_chk_fld
      $error("ratio fields overlap or exceed the word");
   end
   if (!ratio_ok(RESET_RATIO)) begin : g_chk_rst
      $error("reset ratio not supported");
   end

   logic               force_w, trig_w, gate_w, err_w, wrap_w, pend_valid_w;
   logic [RATIO_W-1:0] shadow_w, pend_val_w, act_w, cnt_w;

   cdiv_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS),
      .RATIO_OFS(RATIO_OFS), .CH_IDX(CH_IDX), .TRIG_BIT(TRIG_BIT),
      .EN_BASE(EN_BASE), .ERR_BIT(ERR_BIT), .RATIO_W(RATIO_W),
      .RATIO_LSB(RATIO_LSB), .ACT_LSB(ACT_LSB)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .err_i(err_w), .act_i(act_w), .force_o(force_w), .trig_o(trig_w),
      .gate_o(gate_w), .shadow_o(shadow_w)
   );

   cdiv_reload #(.RATIO_W(RATIO_W)) reload_i (
      .clk(clk), .rst_n(rst_n), .force_i(force_w), .trig_i(trig_w),
      .shadow_i(shadow_w), .wrap_i(wrap_w), .pend_valid_o(pend_valid_w),
      .pend_val_o(pend_val_w), .err_o(err_w)
   );

   cdiv_counter #(
      .RATIO_W(RATIO_W), .RESET_RATIO(RESET_RATIO), .OUT_REG(OUT_REG)
   ) counter_i (
      .clk(clk), .rst_n(rst_n), .gate_i(gate_w),
      .pend_valid_i(pend_valid_w), .pend_val_i(pend_val_w),
      .cnt_o(cnt_w), .act_o(act_w), .wrap_o(wrap_w), .div_clk_o(div_clk_o)
   );
endmodule

// File: rtl/cdiv_chk.sv
module cdiv_chk #(
   parameter int RATIO_W = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               gate,
   input logic               div_clk,
   input logic [RATIO_W-1:0] act,
   input logic [RATIO_W-1:0] cnt,
   input logic               wrap,
   input logic               pend_valid,
   input logic               err
);
   import cdiv_pkg::*;

   assert_act_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_ok(32'(act)));

   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   assert_swap_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (act != $past(act)) |-> ($past(wrap) && $past(pend_valid)));

   assert_gate_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate && !$past(gate)) |-> !div_clk);

   assert_high_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
      div_clk |-> (cnt < (act >> 1)));
endmodule

bind reload_clkdiv cdiv_chk #(.RATIO_W(RATIO_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .gate(gate_w), .div_clk(div_clk_o),
   .act(act_w), .cnt(cnt_w), .wrap(wrap_w), .pend_valid(pend_valid_w),
   .err(err_w)
);

// File: tb/reload_clkdiv_tb_top.sv
module reload_clkdiv_tb_top;
   localparam logic [3:0]  A_CTRL  = 4'h0;
   localparam logic [3:0]  A_RATIO = 4'h8;
   localparam logic [31:0] EN      = 32'h0200_0000;
   localparam logic [31:0] FORCE   = 32'h0000_0002;
   localparam logic [31:0] TRIG    = 32'h0000_0100;
   localparam logic [31:0] JUNK    = 32'h0A00_0003;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        div_clk_o;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   reload_clkdiv dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .div_clk_o(div_clk_o)
   );

   function automatic bit legal(int v);
      return v == 4 || v == 5 || v == 6 || v == 8;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic rd(logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_we = 0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 0;
   endtask

   task automatic reload(int v, logic [31:0] en);
      wr(A_RATIO, JUNK | (32'(v) << 8));
      wr(A_CTRL, en | FORCE);
      wr(A_CTRL, en | FORCE | TRIG);
      repeat (14) @(negedge clk);
      wr(A_CTRL, en);
   endtask

   task automatic measure(output int hi, output int per);
      int g = 0;
      hi = 0; per = 0;
      @(negedge clk);
      while (div_clk_o !== 1'b0 && g < 60) begin @(negedge clk); g++; end
      while (div_clk_o !== 1'b1 && g < 120) begin @(negedge clk); g++; end
      while (div_clk_o === 1'b1 && g < 180) begin hi++; @(negedge clk); g++; end
      per = hi;
      while (div_clk_o === 1'b0 && g < 240) begin per++; @(negedge clk); g++; end
   endtask

   // Period monitor for R9: every completed period must be a supported ratio.
   bit mon_on = 0, seen = 0, prev_o = 0;
   int len = 0, runts = 0;
   always @(negedge clk) begin
      if (mon_on) begin
         if (!prev_o && div_clk_o) begin
            if (seen && !legal(len)) runts++;
            seen = 1; len = 1;
         end else len++;
      end
      prev_o = div_clk_o;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int hi, per, cur;
      bit err_exp;
      int seq[8] = '{4, 5, 6, 8, 5, 8, 4, 6};

      repeat (3) @(negedge clk);
      chk("R1 out", {31'b0, div_clk_o}, 32'h0);
      rst_n = 1;
      rd(A_CTRL, d);  chk("R1 ctrl", d, 32'h0);
      rd(A_RATIO, d); chk("R1 ratio", d, 32'h0004_0000);
      chk("R1 out", {31'b0, div_clk_o}, 32'h0);

      // Reload with gate clear: active changes, output stays low.
      reload(5, 32'h0);
      rd(A_RATIO, d); chk("R4 R10 gated reload", d[21:16], 32'd5);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         chk("R7 gate clear", {31'b0, div_clk_o}, 32'h0);
      end

      // R2 readback, bit 31 write ignored.
      wr(A_CTRL, 32'h8000_0000 | EN);
      rd(A_CTRL, d); chk("R2 bit31 ignored", d, EN);
      wr(A_CTRL, 32'h0034_5600 | EN);
      rd(A_CTRL, d); chk("R2 ctrl readback", d, 32'h0034_5600 | EN);
      wr(A_CTRL, EN);

      // R3 shadow write only.
      wr(A_RATIO, 32'h0000_0800);
      rd(A_RATIO, d); chk("R2 R3 ratio readback", d, 32'h0005_0800);
      measure(hi, per); chk("R3 period unchanged", per, 32'd5);

      // R4 force alone, trigger alone, trigger with other channel force.
      wr(A_CTRL, EN | FORCE); repeat (12) @(negedge clk); wr(A_CTRL, EN);
      rd(A_RATIO, d); chk("R4 force only", d[21:16], 32'd5);
      wr(A_CTRL, EN | TRIG); repeat (12) @(negedge clk); wr(A_CTRL, EN);
      rd(A_RATIO, d); chk("R4 trigger only", d[21:16], 32'd5);
      wr(A_CTRL, EN | TRIG | 32'h1); repeat (12) @(negedge clk); wr(A_CTRL, EN);
      rd(A_RATIO, d); chk("R4 other channel", d[21:16], 32'd5);

      // Valid ratio sequence with period monitor.
      seen = 0; len = 0; mon_on = 1;
      foreach (seq[k]) begin
         reload(seq[k], EN);
         rd(A_RATIO, d);
         chk("R5 R10 active after clear", d, (JUNK | (32'(seq[k]) << 8)) | (32'(seq[k]) << 16));
         measure(hi, per);
         chk("R6 period", per, 32'(seq[k]));
         chk("R6 high phase", hi, 32'(seq[k] / 2));
      end
      chk("R9 no runt period", runts, 32'd0);
      rd(A_CTRL, d); chk("R8 no error yet", d[31], 32'h0);

      // Sweep all field values.
      cur = 6; err_exp = 0;
      for (int v = 0; v < 64; v++) begin
         reload(v, EN);
         if (legal(v)) cur = v; else err_exp = 1;
         rd(A_RATIO, d); chk("R8 active held", d[21:16], 32'(cur));
         rd(A_CTRL, d);  chk("R8 error flag", d[31], {31'b0, err_exp});
      end
      chk("R9 no runt in sweep", runts, 32'd0);
      mon_on = 0;

      // Gate off.
      wr(A_CTRL, 32'h0);
      repeat (2) @(negedge clk);
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         chk("R7 gate off", {31'b0, div_clk_o}, 32'h0);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule